// File: doc/BRIEF.md
# LSB Rounding Requantizer

This block narrows a fixed-point sample by removing its low-order bits. The number of bits removed is the input width minus the output width. It rounds the kept part instead of chopping it, so a long run of samples does not pick up a DC offset. Parameters set the widths, and also choose:

- signed or unsigned arithmetic;
- rounding or plain truncation;
- whether an overflow caused by rounding saturates or wraps.

Register stages can be placed before the rounding logic, after it, or both. With no stages the block is purely combinational. A valid flag travels with every sample and sees the same delay.

A typical use is after an adder that produced one bit of growth. The block is dropped in as a parameterised leaf, and the surrounding logic only watches the valid flag on each side.

Top module: `lsb_round_requant`

## Requirements
- R1: With `IS_SIGNED`=1 and `USE_ROUND`=1, the result is the two's-complement input divided by 2^D and rounded to the nearest integer, where D = `IN_W`-`OUT_W`. A discarded fraction of exactly one half moves away from zero: up for non-negative inputs, down for negative inputs.
- R2: With `IS_SIGNED`=0 and `USE_ROUND`=1, the input is unsigned. The result is input/2^D rounded to nearest, and an exact half always rounds up.
- R3: With `USE_ROUND`=0, the result is the top `OUT_W` bits of the input, which is floor(input/2^D).
- R4: With `USE_CLIP`=1, a rounded value above the output maximum is replaced by that maximum. The maximum is 2^(`OUT_W`-1)-1 when signed and 2^`OUT_W`-1 when unsigned.
- R5: With `USE_CLIP`=0, a rounded value above the output maximum wraps modulo 2^`OUT_W`.
- R6: For a signed 4-bit input reduced to 3 bits, the inputs -4,-3,-2,-1,0,1,2,3 give -2,-2,-1,-1,0,1,1,2.
- R7: For a signed 4-bit input reduced to 3 bits with rounding on, the outputs for the inputs -6 through +6 sum to zero.
- R8: Output data and `outVld` appear exactly `IN_STAGES`+`OUT_STAGES` clocks after the input. With both counts at zero they follow the input in the same cycle.
- R9: While `rst` is high at a clock edge, every register stage clears, so `outVld` and `outData` read 0 afterwards.
- R10: When `IN_W` equals `OUT_W`, the data passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inVld | input | 1 | Input sample valid |
| inData | input | IN_W | Input sample |
| outVld | output | 1 | Output sample valid |
| outData | output | OUT_W | Requantized sample |

## Verification
Each result is due a fixed number of clocks after its input: `IN_STAGES`+`OUT_STAGES`. That is zero for a combinational instance, and up to three for the deepest instance on the bench.

The bench records every applied input by cycle. Half a clock after each rising edge, it checks each instance against the entry recorded that many cycles earlier, and the checks cover both data and valid.

The table check and the zero-mean check use the single-stage 4-to-3 instance, and read its output one cycle after the matching input.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int MAX_STG = 8;

  typedef struct packed {
    logic               flush;
    logic [MAX_STG-1:0] load;
  } rqCtrl_t;
endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int TOT = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inVld,
  output rqCtrl_t ctrl,
  output logic    outVld
);
  localparam int TOTW = (TOT > 0) ? TOT : 1;

  genvar k;
  generate
    if (TOT == 0) begin : gComb
      always_comb begin
        ctrl.flush = rst;
        ctrl.load  = '0;
      end
      assign outVld = inVld;
    end else begin : gPipe
      logic [TOTW-1:0] vldPipe;

      always_ff @(posedge clk) begin
        if (rst) vldPipe <= '0;
        else     vldPipe <= (vldPipe << 1) | TOTW'(inVld);
      end

      always_comb begin
        ctrl.flush   = rst;
        ctrl.load    = '0;
        ctrl.load[0] = inVld;
        for (int i = 1; i < TOT; i++) ctrl.load[i] = vldPipe[i-1];
      end

      assign outVld = vldPipe[TOT-1];

      // R8
      vld_enter_chk: assert property (@(posedge clk) disable iff (rst)
        inVld |=> vldPipe[0]);

      for (k = 0; k < TOT - 1; k++) begin : gShift
        // R8
        vld_shift_chk: assert property (@(posedge clk) disable iff (rst)
          vldPipe[k] |=> vldPipe[k+1]);
      end

      // R9
      rst_clear_chk: assert property (@(posedge clk) rst |=> !outVld);
    end
  endgenerate
endmodule

// File: rtl/rq_dp.sv
module rq_dp
  import rq_pkg::*;
#(
  parameter int IN_W       = 5,
  parameter int OUT_W      = 3,
  parameter int IS_SIGNED  = 1,
  parameter int USE_ROUND  = 1,
  parameter int USE_CLIP   = 0,
  parameter int IN_STAGES  = 1,
  parameter int OUT_STAGES = 1
) (
  input  logic             clk,
  input  rqCtrl_t          ctrl,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData
);
  localparam int DROP = IN_W - OUT_W;

  logic [IN_W-1:0]  stageIn;
  logic [OUT_W-1:0] rounded;
  logic             unusedLoad;

  assign unusedLoad = ^ctrl.load;

  genvar k;
  generate
    for (k = 0; k < IN_STAGES; k++) begin : gInStg
      logic [IN_W-1:0] src;
      logic [IN_W-1:0] q;
      if (k == 0) begin : gFirst
        assign src = inData;
      end else begin : gNext
        assign src = gInStg[k-1].q;
      end
      always_ff @(posedge clk) begin
        if (ctrl.flush)       q <= '0;
        else if (ctrl.load[k]) q <= src;
      end
    end

    if (IN_STAGES == 0) begin : gNoIn
      assign stageIn = inData;
    end else begin : gInTap
      assign stageIn = gInStg[IN_STAGES-1].q;
    end

    if (DROP == 0) begin : gPass
      assign rounded = stageIn;
    end else begin : gRnd
      logic [OUT_W-1:0] upper;
      logic [OUT_W-1:0] maxCode;
      logic             halfBit;
      logic             restNz;
      logic             neg;
      logic             bump;
      logic             atMax;

      assign upper   = stageIn[IN_W-1:DROP];
      assign halfBit = stageIn[DROP-1];
      if (DROP > 1) begin : gRest
        assign restNz = |stageIn[DROP-2:0];
      end else begin : gNoRest
        assign restNz = 1'b0;
      end
      assign neg     = (IS_SIGNED != 0) && stageIn[IN_W-1];
      assign bump    = (USE_ROUND != 0) && halfBit && ((IS_SIGNED == 0) || restNz || !neg);
      assign maxCode = (IS_SIGNED != 0) ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
      assign atMax   = (upper == maxCode);

      always_comb begin
        if ((USE_CLIP != 0) && bump && atMax) rounded = maxCode;
        else                                  rounded = upper + OUT_W'(bump);
      end

      if (USE_CLIP != 0 && IS_SIGNED != 0) begin : gChkS
        // R4
        sign_keep_chk: assert property (@(posedge clk) disable iff (ctrl.flush)
          !stageIn[IN_W-1] |-> !rounded[OUT_W-1]);
      end
      if (USE_CLIP != 0 && IS_SIGNED == 0) begin : gChkU
        // R4
        no_wrap_zero_chk: assert property (@(posedge clk) disable iff (ctrl.flush)
          rounded >= stageIn[IN_W-1:DROP]);
      end
    end

    for (k = 0; k < OUT_STAGES; k++) begin : gOutStg
      logic [OUT_W-1:0] src;
      logic [OUT_W-1:0] q;
      if (k == 0) begin : gFirst
        assign src = rounded;
      end else begin : gNext
        assign src = gOutStg[k-1].q;
      end
      always_ff @(posedge clk) begin
        if (ctrl.flush)                   q <= '0;
        else if (ctrl.load[IN_STAGES+k]) q <= src;
      end
    end

    if (OUT_STAGES == 0) begin : gNoOut
      assign outData = rounded;
    end else begin : gOutTap
      assign outData = gOutStg[OUT_STAGES-1].q;
    end
  endgenerate
endmodule

// File: rtl/lsb_round_requant.sv
module lsb_round_requant
  import rq_pkg::*;
#(
  parameter int IN_W       = 5,
  parameter int OUT_W      = 3,
  parameter int IS_SIGNED  = 1,
  parameter int USE_ROUND  = 1,
  parameter int USE_CLIP   = 0,
  parameter int IN_STAGES  = 1,
  parameter int OUT_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inVld,
  input  logic [IN_W-1:0]  inData,
  output logic             outVld,
  output logic [OUT_W-1:0] outData
);
  localparam int TOT = IN_STAGES + OUT_STAGES;

  rqCtrl_t ctrl;

  rq_ctrl #(.TOT(TOT)) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .inVld (inVld),
    .ctrl  (ctrl),
    .outVld(outVld)
  );

  rq_dp #(
    .IN_W      (IN_W),
    .OUT_W     (OUT_W),
    .IS_SIGNED (IS_SIGNED),
    .USE_ROUND (USE_ROUND),
    .USE_CLIP  (USE_CLIP),
    .IN_STAGES (IN_STAGES),
    .OUT_STAGES(OUT_STAGES)
  ) uDp (
    .clk    (clk),
    .ctrl   (ctrl),
    .inData (inData),
    .outData(outData)
  );
endmodule

// File: tb/sim_lsb_round_requant.sv
`timescale 1ns/1ps
module sim_lsb_round_requant;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inVld = 1'b0;
  logic [4:0] inData = '0;

  logic       v0, v1, v2, v3, v4, v5, v6;
  logic [2:0] d0, d1, d2, d3, d4, d6;
  logic [3:0] d5;

  int compared = 0;
  int mismatched = 0;
  int histD [0:255];
  int histV [0:255];

  always #2.5 clk = ~clk;

  // signed round, wrap, latency 2
  lsb_round_requant #(.IN_W(5), .OUT_W(3), .IS_SIGNED(1), .USE_ROUND(1), .USE_CLIP(0),
    .IN_STAGES(1), .OUT_STAGES(1)) u0 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData), .outVld(v0), .outData(d0));
  // signed round, clip, latency 2
  lsb_round_requant #(.IN_W(5), .OUT_W(3), .IS_SIGNED(1), .USE_ROUND(1), .USE_CLIP(1),
    .IN_STAGES(2), .OUT_STAGES(0)) u1 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData), .outVld(v1), .outData(d1));
  // unsigned round, wrap, latency 1
  lsb_round_requant #(.IN_W(5), .OUT_W(3), .IS_SIGNED(0), .USE_ROUND(1), .USE_CLIP(0),
    .IN_STAGES(0), .OUT_STAGES(1)) u2 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData), .outVld(v2), .outData(d2));
  // unsigned round, clip, combinational
  lsb_round_requant #(.IN_W(5), .OUT_W(3), .IS_SIGNED(0), .USE_ROUND(1), .USE_CLIP(1),
    .IN_STAGES(0), .OUT_STAGES(0)) u3 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData), .outVld(v3), .outData(d3));
  // signed truncation, latency 3
  lsb_round_requant #(.IN_W(5), .OUT_W(3), .IS_SIGNED(1), .USE_ROUND(0), .USE_CLIP(0),
    .IN_STAGES(1), .OUT_STAGES(2)) u4 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData), .outVld(v4), .outData(d4));
  // equal widths, latency 1
  lsb_round_requant #(.IN_W(4), .OUT_W(4), .IS_SIGNED(1), .USE_ROUND(1), .USE_CLIP(0),
    .IN_STAGES(1), .OUT_STAGES(0)) u5 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData[3:0]), .outVld(v5), .outData(d5));
  // signed 4 to 3, latency 1
  lsb_round_requant #(.IN_W(4), .OUT_W(3), .IS_SIGNED(1), .USE_ROUND(1), .USE_CLIP(0),
    .IN_STAGES(0), .OUT_STAGES(1)) u6 (.clk(clk), .rst(rst), .inVld(inVld),
    .inData(inData[3:0]), .outVld(v6), .outData(d6));

  function automatic int refq(int raw, int inW, int outW, bit sg, bit rd, bit cl);
    int v, d, step, fl, fr, r, hi;
    v = raw;
    if (sg && raw >= (1 << (inW - 1))) v = raw - (1 << inW);
    d = inW - outW;
    step = 1 << d;
    fl = (v >= 0) ? v / step : -((-v + step - 1) / step);
    fr = v - fl * step;
    r = fl;
    if (rd && d > 0) begin
      if (2 * fr > step) r = r + 1;
      else if (2 * fr == step && (!sg || v >= 0)) r = r + 1;
    end
    hi = sg ? (1 << (outW - 1)) - 1 : (1 << outW) - 1;
    if (r > hi) r = cl ? hi : r - (1 << outW);
    return r & ((1 << outW) - 1);
  endfunction

  task automatic check(string req, string what, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cmpInst(string nm, string req, int lat, int inW, int outW, bit sg,
                         bit rd, bit cl, int gv, int gd, int c);
    int k, ev, raw;
    k = c - lat;
    ev = histV[k];
    raw = histD[k] & ((1 << inW) - 1);
    check("R8", {nm, " valid"}, gv, ev);
    if (ev != 0) check(req, {nm, " data"}, gd, refq(raw, inW, outW, sg, rd, cl));
  endtask

  initial begin
    int tbl [8] = '{-2, -2, -1, -1, 0, 1, 1, 2};
    int sum = 0;
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (c == 3) begin
        // R9: outputs cleared while reset held
        check("R9", "u0 valid in reset", int'(v0), 0);
        check("R9", "u0 data in reset", int'(d0), 0);
        check("R9", "u4 data in reset", int'(d4), 0);
      end
      if (c < 4) begin
        rst = 1'b1; inVld = 1'b0; inData = '0;
      end else begin
        int idx;
        idx = c - 4;
        rst = 1'b0;
        if (idx < 32) begin
          inVld = 1'b1; inData = 5'(idx);
        end else if (idx < 96) begin
          inVld = (idx % 3) != 0; inData = 5'((idx * 7) % 32);
        end else begin
          inVld = 1'b0; inData = 5'(idx);
        end
      end
      histD[c] = int'(inData);
      histV[c] = int'(inVld);
      #1;
      if (c >= 4) begin
        cmpInst("u0", "R1 R5", 2, 5, 3, 1, 1, 0, int'(v0), int'(d0), c);
        cmpInst("u1", "R1 R4", 2, 5, 3, 1, 1, 1, int'(v1), int'(d1), c);
        cmpInst("u2", "R2 R5", 1, 5, 3, 0, 1, 0, int'(v2), int'(d2), c);
        cmpInst("u3", "R2 R4", 0, 5, 3, 0, 1, 1, int'(v3), int'(d3), c);
        cmpInst("u4", "R3", 3, 5, 3, 1, 0, 0, int'(v4), int'(d4), c);
        cmpInst("u5", "R10", 1, 4, 4, 1, 1, 0, int'(v5), int'(d5), c);
        cmpInst("u6", "R6", 1, 4, 3, 1, 1, 0, int'(v6), int'(d6), c);
        if (c >= 5 && (c - 5) < 16) begin
          int raw, sv, got;
          raw = histD[c-1] & 15;
          sv = (raw >= 8) ? raw - 16 : raw;
          got = (d6 >= 3'd4) ? int'(d6) - 8 : int'(d6);
          if (sv >= -4 && sv <= 3) check("R6", "table entry", got, tbl[sv + 4]);
          if (sv >= -6 && sv <= 6) sum += got;
        end
      end
    end
    // R7: zero mean over symmetric range
    check("R7", "sum over -6..6", sum, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule